// File: doc/BRIEF.md
# Interrupt Dispatch and Fault Escalation Unit

This unit decides, at each instruction boundary, whether an interrupt is taken and where its handler starts. Requests come from three places. Software raises an interrupt with a vector index and a 64-bit auxiliary word. Hardware request lines are level inputs. Internal error events cover an illegal instruction, an illegal memory address and a divide by zero. The unit keeps software and error requests pending until a boundary consumes them. It then picks the request with the highest priority and checks the global enable. It reads the 64-bit table entry for that vector from memory, checks the entry's own enable bit and works out the handler address. It passes the vector, the auxiliary word and the handler address to the frame sequencer as a one-cycle dispatch pulse.

The unit keeps a small record of open handler frames, noting for each one whether it belongs to an error-state vector (below 0x80). A second error taken while one error frame is open becomes a double fault on vector 0. An error taken while two error frames are open is a triple fault: it sets the sticky halt output and no table read is made. The frame sequencer signals each completed interrupt return, and that closes the newest open frame.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, `disp_valid`, `mem_rd_req` and `halt` are 0.
- R2: A request is serviced only on a cycle where `insn_done` is high. In the next cycle `mem_rd_req` is high with `mem_rd_addr` = `ivt_base` + 8 × vector. It stays high, with a stable address, until `mem_rd_valid`. `ivt_base` is assumed to be a multiple of 64.
- R3: If `flags_ie` is 0 at the boundary, the selected request is dropped without a table read, and a later boundary with `flags_ie` = 1 does not serve it.
- R4: If bit 63 of the returned entry is 0, the request is dropped: `disp_valid` stays low.
- R5: The handler address is entry bits 57:0 shifted left by 6 (the 59-bit field in bits 58:0 times 64, truncated to 64 bits). Bits 62:59 are ignored. `disp_valid` pulses for exactly one cycle, in the cycle after `mem_rd_valid`.
- R6: Priority is error events, then software, then hardware. Hardware line i maps to vector 0x80 + i, uses `hw_aux`, and the lowest set line wins.
- R7: `err_evt` bit 0 (illegal instruction) maps to vector 1, bit 1 (illegal memory address) to vector 2, and bit 2 (divide by zero) to vector 3. Each error keeps the `err_aux` value from its event cycle. Among pending errors the lowest vector goes first.
- R8: An error-state vector (below 0x80) taken while exactly one error frame is open is dispatched as vector 0, with auxiliary word equal to the vector that was invoked.
- R9: An error-state vector taken while two or more error frames are open sets `halt`, whatever `flags_ie` is. No table read is made. `halt` stays set and no further table read or dispatch happens until reset.
- R10: `iret_done` closes the newest open frame. Closing an error frame lets the next error dispatch normally. Closing a non-error frame leaves the error nesting unchanged.
- R11: A software request dispatches its own 9-bit vector and 64-bit auxiliary word unchanged.
- R12: A request dropped by R3 or R4 opens no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_done | input | 1 | Instruction boundary strobe |
| flags_ie | input | 1 | Global interrupt enable flag |
| ivt_base | input | 64 | Vector table base address |
| sw_req | input | 1 | Software interrupt request pulse |
| sw_vec | input | 9 | Software vector index |
| sw_aux | input | 64 | Software auxiliary word |
| hw_req | input | HW_N | Hardware request levels |
| hw_aux | input | 64 | Auxiliary word for hardware requests |
| err_evt | input | 3 | Error event pulses (see R7) |
| err_aux | input | 64 | Auxiliary word for error events |
| iret_done | input | 1 | Interrupt return completed |
| mem_rd_req | output | 1 | Table entry read request |
| mem_rd_addr | output | 64 | Table entry address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Table entry |
| disp_valid | output | 1 | Dispatch pulse to frame sequencer |
| disp_vec | output | 9 | Dispatched vector |
| disp_aux | output | 64 | Dispatched auxiliary word |
| disp_handler | output | 64 | Handler start address |
| halt | output | 1 | Triple fault halt, sticky |

## Verification
The bench targets the escalation ladder. A design that counts every open frame, instead of only error frames, would raise a double fault after an ordinary software handler closed. A design that decrements on every return would lose a pending double fault. The tests also cover a dropped entry that wrongly opens a frame (the next error then comes out as vector 0), a triple fault that is gated by the global enable, and reserved entry bits that leak into the handler address. Priority tests hold error, software and hardware requests all pending at once, so an inverted order shows up as the wrong vector.

// File: rtl/irq_pkg.sv
// Package: shared widths, field positions and enums for the dispatch unit.
// Assumes 64-bit addresses and a 512-entry table of 8-byte entries.
package irq_pkg;
    localparam int VEC_W      = 9;
    localparam int ADDR_W     = 64;
    localparam int DATA_W     = 64;
    localparam int ENT_LG     = 3;
    localparam int HND_SHIFT  = 6;
    localparam int EN_BIT     = 63;
    localparam int FIELD_W    = 59;
    localparam int NUM_ERR    = 3;
    localparam int ERR_IDX_W  = 2;
    localparam logic [VEC_W-1:0] ERR_LIMIT = 9'h080;
    localparam logic [VEC_W-1:0] DBL_VEC   = 9'h000;

    typedef enum logic [1:0] {SRC_NONE, SRC_ERR, SRC_SW, SRC_HW} src_e;
    typedef enum logic {ST_IDLE, ST_FETCH} st_e;
endpackage

// File: rtl/irq_pick.sv
// Module: fixed-priority selection among pending requests.
// Errors beat software, software beats hardware; lowest index wins within
// errors and within hardware lines. Purely combinational.
module irq_pick
    import irq_pkg::*;
#(
    parameter int HW_N = 8,
    parameter logic [VEC_W-1:0] HW_BASE = 9'h080
) (
    input  logic [NUM_ERR-1:0]             err_pend,
    input  logic [NUM_ERR-1:0][DATA_W-1:0] err_aux_arr,
    input  logic                           sw_pend,
    input  logic [VEC_W-1:0]               sw_vec,
    input  logic [DATA_W-1:0]              sw_aux,
    input  logic [HW_N-1:0]                hw_req,
    input  logic [DATA_W-1:0]              hw_aux,
    output src_e                           sel_src,
    output logic [ERR_IDX_W-1:0]           sel_err_idx,
    output logic [VEC_W-1:0]               sel_vec,
    output logic [DATA_W-1:0]              sel_aux
);
    localparam int HW_IDX_W = (HW_N > 1) ? $clog2(HW_N) : 1;

    logic                 err_hit, hw_hit;
    logic [HW_IDX_W-1:0]  hw_idx;

    // Lowest set index among error and hardware requests.
    always_comb begin
        err_hit     = 1'b0;
        sel_err_idx = '0;
        for (int i = NUM_ERR - 1; i >= 0; i--) begin
            if (err_pend[i]) begin
                err_hit     = 1'b1;
                sel_err_idx = ERR_IDX_W'(i);
            end
        end
        hw_hit = 1'b0;
        hw_idx = '0;
        for (int i = HW_N - 1; i >= 0; i--) begin
            if (hw_req[i]) begin
                hw_hit = 1'b1;
                hw_idx = HW_IDX_W'(i);
            end
        end
    end

    // Class priority and vector/aux formation.
    always_comb begin
        sel_src = SRC_NONE;
        sel_vec = '0;
        sel_aux = '0;
        if (err_hit) begin
            sel_src = SRC_ERR;
            sel_vec = VEC_W'(sel_err_idx) + VEC_W'(1);
            sel_aux = err_aux_arr[sel_err_idx];
        end else if (sw_pend) begin
            sel_src = SRC_SW;
            sel_vec = sw_vec;
            sel_aux = sw_aux;
        end else if (hw_hit) begin
            sel_src = SRC_HW;
            sel_vec = HW_BASE + VEC_W'(hw_idx);
            sel_aux = hw_aux;
        end
    end
endmodule

// File: rtl/irq_nest.sv
// Module: record of open handler frames, one bit per frame marking an
// error-state frame. Reports how many open frames are error frames.
// Assumes pushes beyond DEPTH are dropped and pops on empty are ignored.
module irq_nest #(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic                        push_err,
    input  logic                        pop,
    output logic [$clog2(DEPTH+1)-1:0]  err_cnt
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] kind_q;
    logic [LVL_W-1:0] lvl_q;
    logic [IDX_W-1:0] top_idx, new_idx;

    assign top_idx = IDX_W'(lvl_q - LVL_W'(1));
    assign new_idx = IDX_W'(lvl_q);
    assign err_cnt = LVL_W'($countones(kind_q));

    // Push/pop of frame kinds; a simultaneous push and pop replaces the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= '0;
            lvl_q  <= '0;
        end else if (push && pop && lvl_q != '0) begin
            kind_q[top_idx] <= push_err;
        end else if (push && lvl_q != LVL_W'(DEPTH)) begin
            kind_q[new_idx] <= push_err;
            lvl_q           <= lvl_q + LVL_W'(1);
        end else if (pop && !push && lvl_q != '0) begin
            kind_q[top_idx] <= 1'b0;
            lvl_q           <= lvl_q - LVL_W'(1);
        end
    end
endmodule

// File: rtl/irq_dispatch.sv
// Module: top of the dispatch unit. Latches software and error requests,
// selects one at an instruction boundary, applies global enable and fault
// escalation, fetches the table entry and issues a one-cycle dispatch.
// Assumes ivt_base is 64-byte aligned and boundaries during a fetch are ignored.
module irq_dispatch
    import irq_pkg::*;
#(
    parameter int HW_N = 8,
    parameter logic [VEC_W-1:0] HW_BASE = 9'h080,
    parameter int NEST_MAX = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 insn_done,
    input  logic                 flags_ie,
    input  logic [ADDR_W-1:0]    ivt_base,
    input  logic                 sw_req,
    input  logic [VEC_W-1:0]     sw_vec,
    input  logic [DATA_W-1:0]    sw_aux,
    input  logic [HW_N-1:0]      hw_req,
    input  logic [DATA_W-1:0]    hw_aux,
    input  logic [NUM_ERR-1:0]   err_evt,
    input  logic [DATA_W-1:0]    err_aux,
    input  logic                 iret_done,
    output logic                 mem_rd_req,
    output logic [ADDR_W-1:0]    mem_rd_addr,
    input  logic                 mem_rd_valid,
    input  logic [DATA_W-1:0]    mem_rd_data,
    output logic                 disp_valid,
    output logic [VEC_W-1:0]     disp_vec,
    output logic [DATA_W-1:0]    disp_aux,
    output logic [ADDR_W-1:0]    disp_handler,
    output logic                 halt
);
    localparam int LVL_W = $clog2(NEST_MAX + 1);

    st_e                            st_q;
    logic                           halt_q;
    logic [NUM_ERR-1:0]             err_pend;
    logic [NUM_ERR-1:0][DATA_W-1:0] err_aux_arr;
    logic                           sw_pend_q;
    logic [VEC_W-1:0]               sw_vec_q;
    logic [DATA_W-1:0]              sw_aux_q;
    src_e                           sel_src;
    logic [ERR_IDX_W-1:0]           sel_err_idx;
    logic [VEC_W-1:0]               sel_vec;
    logic [DATA_W-1:0]              sel_aux;
    logic [LVL_W-1:0]               err_cnt;
    logic                           take, sel_is_err, is_double, is_triple;
    logic                           cur_err_q, push;
    logic [VEC_W-1:0]               cur_vec_q, next_vec;
    logic [DATA_W-1:0]              cur_aux_q, next_aux;

    assign take       = insn_done && (st_q == ST_IDLE) && !halt_q && (sel_src != SRC_NONE);
    assign sel_is_err = sel_vec < ERR_LIMIT;
    assign is_triple  = sel_is_err && (err_cnt >= LVL_W'(2));
    assign is_double  = sel_is_err && (err_cnt == LVL_W'(1));
    assign next_vec   = is_double ? DBL_VEC : sel_vec;
    assign next_aux   = is_double ? DATA_W'(sel_vec) : sel_aux;
    assign push       = (st_q == ST_FETCH) && mem_rd_valid && mem_rd_data[EN_BIT];
    assign mem_rd_req = (st_q == ST_FETCH);
    assign halt       = halt_q;

    // One pending flag and captured aux word per error source.
    for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
        logic              pend_q;
        logic [DATA_W-1:0] aux_q;
        // Set on the event, cleared when this source is consumed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                aux_q  <= '0;
            end else if (err_evt[g]) begin
                pend_q <= 1'b1;
                aux_q  <= err_aux;
            end else if (take && sel_src == SRC_ERR && sel_err_idx == ERR_IDX_W'(g)) begin
                pend_q <= 1'b0;
            end
        end
        assign err_pend[g]    = pend_q;
        assign err_aux_arr[g] = aux_q;
    end

    // Software request latch, cleared when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_pend_q <= 1'b0;
            sw_vec_q  <= '0;
            sw_aux_q  <= '0;
        end else if (sw_req) begin
            sw_pend_q <= 1'b1;
            sw_vec_q  <= sw_vec;
            sw_aux_q  <= sw_aux;
        end else if (take && sel_src == SRC_SW) begin
            sw_pend_q <= 1'b0;
        end
    end

    irq_pick #(.HW_N(HW_N), .HW_BASE(HW_BASE)) u_pick (
        .err_pend    (err_pend),
        .err_aux_arr (err_aux_arr),
        .sw_pend     (sw_pend_q),
        .sw_vec      (sw_vec_q),
        .sw_aux      (sw_aux_q),
        .hw_req      (hw_req),
        .hw_aux      (hw_aux),
        .sel_src     (sel_src),
        .sel_err_idx (sel_err_idx),
        .sel_vec     (sel_vec),
        .sel_aux     (sel_aux)
    );

    irq_nest #(.DEPTH(NEST_MAX)) u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_err (cur_err_q),
        .pop      (iret_done),
        .err_cnt  (err_cnt)
    );

    // Boundary decision, table fetch and halt on triple fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            halt_q      <= 1'b0;
            cur_vec_q   <= '0;
            cur_aux_q   <= '0;
            cur_err_q   <= 1'b0;
            mem_rd_addr <= '0;
        end else if (st_q == ST_IDLE) begin
            if (take && is_triple) begin
                halt_q <= 1'b1;
            end else if (take && flags_ie) begin
                st_q        <= ST_FETCH;
                cur_vec_q   <= next_vec;
                cur_aux_q   <= next_aux;
                cur_err_q   <= sel_is_err;
                mem_rd_addr <= ivt_base + (ADDR_W'(next_vec) << ENT_LG);
            end
        end else if (mem_rd_valid) begin
            st_q <= ST_IDLE;
        end
    end

    // One-cycle dispatch pulse with handler address from the entry field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_valid   <= 1'b0;
            disp_vec     <= '0;
            disp_aux     <= '0;
            disp_handler <= '0;
        end else begin
            disp_valid <= push;
            if (push) begin
                disp_vec     <= cur_vec_q;
                disp_aux     <= cur_aux_q;
                disp_handler <= ADDR_W'({mem_rd_data[FIELD_W-1:0], HND_SHIFT'(0)});
            end
        end
    end
endmodule

// File: rtl/irq_dispatch_chk.sv
// Module: property checker for irq_dispatch, attached by bind below.
module irq_dispatch_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              insn_done,
    input logic              flags_ie,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic [DATA_W-1:0] mem_rd_data,
    input logic              disp_valid,
    input logic [ADDR_W-1:0] disp_handler,
    input logic              halt
);
    // R2
    fetch_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_req) |-> $past(insn_done));
    // R2
    fetch_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
    // R3
    masked_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_req && !flags_ie) |=> !mem_rd_req);
    // R4
    dispatch_needs_enabled_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> $past(mem_rd_req && mem_rd_valid && mem_rd_data[EN_BIT]));
    // R5
    handler_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_handler[HND_SHIFT-1:0] == '0));
    // R5
    dispatch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !disp_valid);
    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);
    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!mem_rd_req && !disp_valid));
endmodule

bind irq_dispatch irq_dispatch_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_done    (insn_done),
    .flags_ie     (flags_ie),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .disp_valid   (disp_valid),
    .disp_handler (disp_handler),
    .halt         (halt)
);

// File: tb/irq_dispatch_bench.sv
`timescale 1ns/1ps
module irq_dispatch_bench;
    localparam logic [63:0] BASE = 64'h0000_0000_0004_0000;

    typedef struct packed {
        logic [1:0]  src;      // 0 sw, 1 hw, 2 err, 3 none
        logic [8:0]  code;
        logic [63:0] aux;
        logic [63:0] entry;
        logic [8:0]  exp_vec;
        logic [63:0] exp_aux;
        logic        iret;
    } row_t;

    localparam row_t ROWS [8] = '{
        '{2'd0, 9'h100, 64'h1234,          64'h8000_0000_0000_0010, 9'h100, 64'h1234,          1'b0},
        '{2'd0, 9'h1FF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF800_0000_0000_0001, 9'h1FF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        '{2'd1, 9'h060, 64'hAA,            64'h8000_0000_0000_0020, 9'h085, 64'hAA,            1'b0},
        '{2'd1, 9'h001, 64'hBB,            64'h8000_0000_0000_0021, 9'h080, 64'hBB,            1'b0},
        '{2'd2, 9'h004, 64'h77,            64'h8000_0000_0000_0030, 9'h003, 64'h77,            1'b1},
        '{2'd2, 9'h001, 64'h500,           64'h8000_0000_0000_0031, 9'h001, 64'h500,           1'b1},
        '{2'd2, 9'h006, 64'h66,            64'h8000_0000_0000_0032, 9'h002, 64'h66,            1'b1},
        '{2'd3, 9'h000, 64'h0,             64'h8000_0000_0000_0033, 9'h003, 64'h66,            1'b1}
    };

    logic        clk = 1'b0, rst_n = 1'b0, insn_done = 1'b0, flags_ie = 1'b1;
    logic        sw_req = 1'b0, iret_done = 1'b0, mem_rd_valid = 1'b0;
    logic [8:0]  sw_vec = '0;
    logic [63:0] sw_aux = '0, hw_aux = '0, err_aux = '0, mem_rd_data = '0;
    logic [7:0]  hw_req = '0;
    logic [2:0]  err_evt = '0;
    logic        mem_rd_req, disp_valid, halt;
    logic [63:0] mem_rd_addr, disp_aux, disp_handler;
    logic [8:0]  disp_vec;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_dispatch u_irq_dispatch (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .flags_ie(flags_ie),
        .ivt_base(BASE), .sw_req(sw_req), .sw_vec(sw_vec), .sw_aux(sw_aux),
        .hw_req(hw_req), .hw_aux(hw_aux), .err_evt(err_evt), .err_aux(err_aux),
        .iret_done(iret_done), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .disp_valid(disp_valid), .disp_vec(disp_vec), .disp_aux(disp_aux),
        .disp_handler(disp_handler), .halt(halt)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; flags_ie = 1'b1; hw_req = '0; err_evt = '0; sw_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic raise_sw(input logic [8:0] v, input logic [63:0] a);
        @(negedge clk); sw_req = 1'b1; sw_vec = v; sw_aux = a;
        @(negedge clk); sw_req = 1'b0;
    endtask

    task automatic raise_err(input logic [2:0] e, input logic [63:0] a);
        @(negedge clk); err_evt = e; err_aux = a;
        @(negedge clk); err_evt = '0;
    endtask

    task automatic do_iret();
        @(negedge clk); iret_done = 1'b1;
        @(negedge clk); iret_done = 1'b0;
    endtask

    // Boundary that must fetch and then dispatch (or not, if exp_disp is 0).
    task automatic take(input string req, input logic [8:0] ev, input logic [63:0] ea,
                        input logic [63:0] entry, input bit exp_disp);
        @(negedge clk); insn_done = 1'b1;
        @(negedge clk); insn_done = 1'b0;
        check(mem_rd_req == 1'b1, req, 64'(mem_rd_req), 64'd1);
        check(mem_rd_addr == BASE + 64'(ev) * 8, req, mem_rd_addr, BASE + 64'(ev) * 8);
        mem_rd_valid = 1'b1; mem_rd_data = entry;
        @(negedge clk); mem_rd_valid = 1'b0;
        check(disp_valid == exp_disp, req, 64'(disp_valid), 64'(exp_disp));
        if (exp_disp) begin
            check(disp_vec == ev, req, 64'(disp_vec), 64'(ev));
            check(disp_aux == ea, req, disp_aux, ea);
            check(disp_handler == {entry[57:0], 6'b0}, req, disp_handler, {entry[57:0], 6'b0});
        end
        @(negedge clk);
        check(disp_valid == 1'b0, "R5 single pulse", 64'(disp_valid), 64'd0);
    endtask

    // Boundary that must not produce a table read.
    task automatic no_take(input string req);
        @(negedge clk); insn_done = 1'b1;
        @(negedge clk); insn_done = 1'b0;
        check(mem_rd_req == 1'b0, req, 64'(mem_rd_req), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check(disp_valid == 1'b0, "R1 disp_valid", 64'(disp_valid), 64'd0);
        check(mem_rd_req == 1'b0, "R1 mem_rd_req", 64'(mem_rd_req), 64'd0);
        check(halt == 1'b0, "R1 halt", 64'(halt), 64'd0);

        // Table walk: R5 R6 R7 R11
        for (int i = 0; i < 8; i++) begin
            case (ROWS[i].src)
                2'd0: raise_sw(ROWS[i].code, ROWS[i].aux);
                2'd1: begin @(negedge clk); hw_req = ROWS[i].code[7:0]; hw_aux = ROWS[i].aux; end
                2'd2: raise_err(ROWS[i].code[2:0], ROWS[i].aux);
                default: ;
            endcase
            take("R6/R7/R11 table row", ROWS[i].exp_vec, ROWS[i].exp_aux, ROWS[i].entry, 1'b1);
            hw_req = '0;
            if (ROWS[i].iret) do_iret();
        end

        // R2: pending request waits for a boundary; empty boundary reads nothing
        raise_sw(9'h0A0, 64'h5);
        repeat (4) @(negedge clk);
        check(mem_rd_req == 1'b0, "R2 no boundary", 64'(mem_rd_req), 64'd0);
        take("R2 boundary", 9'h0A0, 64'h5, 64'h8000_0000_0000_0001, 1'b1);
        no_take("R2 nothing pending");

        // R3: global disable drops the request for good
        raise_sw(9'h0A1, 64'h6);
        flags_ie = 1'b0;
        no_take("R3 masked");
        flags_ie = 1'b1;
        no_take("R3 dropped stays dropped");

        // R4 / R12: disabled entry drops and opens no frame
        raise_err(3'b001, 64'h9);
        take("R4 entry disabled", 9'h001, 64'h9, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0);
        raise_err(3'b010, 64'hA);
        take("R12 no frame after drop", 9'h002, 64'hA, 64'h8000_0000_0000_0002, 1'b1);
        do_iret();

        // R6: all three classes pending together
        raise_sw(9'h0C0, 64'h11);
        @(negedge clk); hw_req = 8'h04; hw_aux = 64'h22;
        raise_err(3'b100, 64'h33);
        take("R6 error first", 9'h003, 64'h33, 64'h8000_0000_0000_0003, 1'b1);
        do_iret();
        take("R6 software second", 9'h0C0, 64'h11, 64'h8000_0000_0000_0004, 1'b1);
        do_iret();
        take("R6 hardware third", 9'h082, 64'h22, 64'h8000_0000_0000_0005, 1'b1);
        do_iret();
        hw_req = '0;

        // R8 then R9: double fault, then triple fault with enable clear
        raise_err(3'b001, 64'h40);
        take("R8 first error", 9'h001, 64'h40, 64'h8000_0000_0000_0006, 1'b1);
        raise_err(3'b100, 64'h41);
        take("R8 double fault", 9'h000, 64'h3, 64'h8000_0000_0000_0007, 1'b1);
        raise_err(3'b010, 64'h42);
        flags_ie = 1'b0;
        no_take("R9 triple no fetch");
        check(halt == 1'b1, "R9 halt set", 64'(halt), 64'd1);
        flags_ie = 1'b1;
        raise_sw(9'h0F0, 64'h1);
        no_take("R9 halted ignores requests");
        check(halt == 1'b1, "R9 halt sticky", 64'(halt), 64'd1);

        // R10: closing a non-error frame keeps the error nesting
        do_reset();
        raise_err(3'b001, 64'h50);
        take("R10 open error", 9'h001, 64'h50, 64'h8000_0000_0000_0008, 1'b1);
        raise_sw(9'h090, 64'h51);
        take("R10 open sw", 9'h090, 64'h51, 64'h8000_0000_0000_0009, 1'b1);
        do_iret();
        raise_err(3'b100, 64'h52);
        take("R10 still double", 9'h000, 64'h3, 64'h8000_0000_0000_000A, 1'b1);

        // R10: closing the error frame lets the next error through normally
        do_reset();
        raise_err(3'b001, 64'h60);
        take("R10 open error 2", 9'h001, 64'h60, 64'h8000_0000_0000_000B, 1'b1);
        do_iret();
        raise_err(3'b100, 64'h61);
        take("R10 normal after iret", 9'h003, 64'h61, 64'h8000_0000_0000_000C, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule